// File: doc/BRIEF.md
# Asynchronous Serial Frame Engine

This block turns bytes into asynchronous serial frames on a transmit line and rebuilds bytes from frames arriving on a receive line. All bit timing is derived from an oversampling enable, `os_tick`, that the surrounding clock logic pulses at OSR times the bit rate (16 by default). A bit lasts exactly OSR ticks. Clock cycles without a tick do not advance the timing.

A two-bit format field selects one of three frame shapes: a full byte alone, a full byte plus a parity bit, or seven data bits plus a parity bit. Further configuration inputs choose one or two stop bits, odd or even parity, and whether parity, framing and overrun errors are checked. Transmit traffic goes through a one-byte holding buffer with an empty flag. Receive traffic lands in a one-byte buffer with a data-available flag.

The receiver-enable state and the three sticky error flags are never written directly. They change only through single-cycle command strobes that set or clear them. Software therefore clears exactly the condition it has handled and leaves the others untouched.

Top module: `serial_frame_engine`

## Requirements
- R1: Each transmitted frame has a 0 start bit, then data least significant bit first, then an optional parity bit, then stop bits at 1. `cfg_fmt` 2'b00 sends 8 data bits with no parity, 2'b01 sends 8 data bits plus parity, 2'b10 sends the low 7 data bits plus parity, and 2'b11 behaves like 2'b00.
- R2: `cfg_two_stop`=1 gives 2 stop bits and 0 gives 1 stop bit, on both transmit and receive. With two stop bits, a 0 in either stop bit counts as a framing fault.
- R3: In the parity formats, a parity bit is always sent. With `cfg_par_odd`=1 the data bits plus the parity bit hold an odd number of ones; with 0 they hold an even number.
- R4: `txd` idles at 1 and `tx_empty` is 1 after reset. `tx_wr` while `tx_empty`=1 captures `tx_data`. `tx_empty` returns to 1 once the byte has moved into the shifter, even while the frame is still being sent. `tx_wr` while `tx_empty`=0 is ignored.
- R5: `rx_enabled` is 0 after reset. A `cmd_wr` cycle with `cmd_rx_on` sets it and one with `cmd_rx_off` clears it; set wins when both are given. Frames that start while it is 0 are not received.
- R6: A falling edge on the synchronized `rxd` starts a frame. The start bit is confirmed OSR/2 ticks later. A low pulse that is gone by then is dropped. Every following bit is sampled OSR ticks after the previous one.
- R7: A completed frame sets `rx_avail` and places the byte on `rx_data`. In the 7-bit format `rx_data[7]` reads 0. A one-cycle `rx_rd` clears `rx_avail`.
- R8: In a parity format with `cfg_par_chk`=1, a parity mismatch sets `err_parity`. The byte is still delivered.
- R9: With `cfg_frame_chk`=1, a stop bit sampled as 0 sets `err_frame`. With `cfg_frame_chk`=0 it does not.
- R10: A frame that completes while `rx_avail`=1 (and no `rx_rd` that cycle) is discarded, and `rx_data` keeps the earlier byte. If `cfg_ovr_chk`=1, `err_overrun` is set.
- R11: The error flags are 0 after reset and stay set until a `cmd_wr` cycle carries their own clear bit (`cmd_clr_frame`, `cmd_clr_par`, `cmd_clr_ovr`). A clear bit for one flag leaves the others alone.
- R12: Bit timing advances only on cycles with `os_tick`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| os_tick | input | 1 | Oversampling enable, OSR pulses per bit |
| cfg_fmt | input | 2 | Frame format select |
| cfg_two_stop | input | 1 | Two stop bits when 1 |
| cfg_par_odd | input | 1 | Odd parity when 1, even when 0 |
| cfg_par_chk | input | 1 | Enable parity error detection |
| cfg_frame_chk | input | 1 | Enable framing error detection |
| cfg_ovr_chk | input | 1 | Enable overrun error detection |
| cmd_wr | input | 1 | Command strobe |
| cmd_rx_on | input | 1 | Set receiver enable |
| cmd_rx_off | input | 1 | Clear receiver enable |
| cmd_clr_frame | input | 1 | Clear framing error flag |
| cmd_clr_par | input | 1 | Clear parity error flag |
| cmd_clr_ovr | input | 1 | Clear overrun error flag |
| tx_wr | input | 1 | Write transmit buffer |
| tx_data | input | DW | Byte to transmit |
| tx_empty | output | 1 | Transmit buffer empty |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| rx_rd | input | 1 | Read strobe, frees the receive buffer |
| rx_data | output | DW | Received byte |
| rx_avail | output | 1 | Receive buffer holds unread data |
| rx_enabled | output | 1 | Receiver enable state |
| err_frame | output | 1 | Sticky framing error |
| err_parity | output | 1 | Sticky parity error |
| err_overrun | output | 1 | Sticky overrun error |

## Verification
Some rules hold on every cycle, and the assertions check those. The transmit buffer fills only on a write. A frame begins with a low start bit. The transmit line holds still between ticks. The receiver completes a frame only while it is enabled, and only after a confirmed low start sample. Error flags drop only on their own clear command. An overrun needs a full buffer, and a held byte is never overwritten. The actual bit patterns on the line — parity values, stop-bit counts, the 7-bit mask and glitch rejection — can only be shown by the bench's scenarios. Those scenarios build frames independently and compare them bit by bit.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
   typedef enum logic [1:0] {
      FMT_8N  = 2'b00,
      FMT_8P  = 2'b01,
      FMT_7P  = 2'b10,
      FMT_RSV = 2'b11
   } fmt_e;
endpackage

// File: rtl/sfe_tx.sv
module sfe_tx
   import sfe_pkg::*;
#(
   parameter int OSR = 16,
   parameter int DW  = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  fmt_e          fmt,
   input  logic          two_stop,
   input  logic          par_odd,
   input  logic          wr,
   input  logic [DW-1:0] wdata,
   output logic          empty,
   output logic          txd
);
   localparam int CNT_W   = $clog2(OSR);
   localparam int FRAME_W = DW + 4;
   localparam int NB_W    = $clog2(FRAME_W + 1);
   localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(OSR - 1);

   logic [DW-1:0]      hold_q;
   logic               full_q;
   logic               busy_q;
   logic [FRAME_W-1:0] sh_q;
   logic [NB_W-1:0]    left_q;
   logic [CNT_W-1:0]   tcnt_q;

   logic [DW-1:0]      d_eff;
   logic               par_bit;
   logic [FRAME_W-1:0] frm;
   logic [NB_W-1:0]    nbits;

   always_comb begin
      d_eff = hold_q;
      if (fmt == FMT_7P) d_eff[DW-1] = 1'b0;
      par_bit = (^d_eff) ^ par_odd;
      frm        = '1;
      frm[0]     = 1'b0;
      frm[DW:1]  = d_eff;
      if (fmt == FMT_7P)      frm[DW]   = par_bit;
      else if (fmt == FMT_8P) frm[DW+1] = par_bit;
      nbits = NB_W'(DW + 2) + NB_W'(fmt == FMT_8P) + NB_W'(two_stop);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q <= '0;
         full_q <= 1'b0;
         busy_q <= 1'b0;
         sh_q   <= '1;
         left_q <= '0;
         tcnt_q <= '0;
      end else begin
         if (!busy_q && full_q) begin
            sh_q   <= frm;
            left_q <= nbits;
            busy_q <= 1'b1;
            full_q <= 1'b0;
            tcnt_q <= '0;
         end else if (busy_q && tick) begin
            if (tcnt_q == LAST_TICK) begin
               tcnt_q <= '0;
               sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
               left_q <= left_q - 1'b1;
               if (left_q == NB_W'(1)) busy_q <= 1'b0;
            end else begin
               tcnt_q <= tcnt_q + 1'b1;
            end
         end
         if (wr && !full_q) begin
            hold_q <= wdata;
            full_q <= 1'b1;
         end
      end
   end

   assign empty = !full_q;
   assign txd   = busy_q ? sh_q[0] : 1'b1;

   AST_TX_FILL_NEEDS_WR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(full_q) |-> $past(wr)); // R4
   AST_TX_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> !txd); // R1
   AST_TX_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !tick) |=> $stable(txd)); // R12
endmodule

// File: rtl/sfe_rx.sv
module sfe_rx
   import sfe_pkg::*;
#(
   parameter int OSR         = 16,
   parameter int DW          = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          en,
   input  fmt_e          fmt,
   input  logic          two_stop,
   input  logic          par_odd,
   input  logic          rxd,
   output logic          done,
   output logic [DW-1:0] rbyte,
   output logic          par_bad,
   output logic          stop_bad
);
   localparam int CNT_W = $clog2(OSR);
   localparam int VEC_W = DW + 3;
   localparam int IDX_W = $clog2(VEC_W);
   localparam logic [CNT_W-1:0] HALF_TICK = CNT_W'(OSR / 2 - 1);
   localparam logic [CNT_W-1:0] FULL_TICK = CNT_W'(OSR - 1);

   typedef enum logic [1:0] {S_IDLE, S_START, S_BITS} rx_st_e;

   logic rxs;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign rxs = rxd;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sr_q;
         always_ff @(posedge clk) begin
            if (!rst_n) sr_q <= '1;
            else begin
               sr_q[0] <= rxd;
               for (int i = 1; i < SYNC_STAGES; i++) sr_q[i] <= sr_q[i-1];
            end
         end
         assign rxs = sr_q[SYNC_STAGES-1];
      end
   endgenerate

   rx_st_e           st_q;
   logic             prev_q;
   logic [CNT_W-1:0] tcnt_q;
   logic [IDX_W-1:0] idx_q;
   logic [VEC_W-1:0] vec_q;
   fmt_e             fmt_q;
   logic             ts_q;
   logic             po_q;
   logic             done_q;

   logic [IDX_W-1:0] last_idx;
   logic [IDX_W-1:0] stop_pos;
   logic             pbit;

   always_comb begin
      last_idx = IDX_W'(DW) + IDX_W'(fmt_q == FMT_8P) + IDX_W'(ts_q);
      stop_pos = IDX_W'(DW) + IDX_W'(fmt_q == FMT_8P);
      rbyte    = vec_q[DW-1:0];
      pbit     = (fmt_q == FMT_7P) ? vec_q[DW-1] : vec_q[DW];
      if (fmt_q == FMT_7P) rbyte[DW-1] = 1'b0;
      par_bad  = ((fmt_q == FMT_8P) || (fmt_q == FMT_7P)) &&
                 (((^rbyte) ^ pbit) != po_q);
      stop_bad = !vec_q[stop_pos] || (ts_q && !vec_q[stop_pos + 1'b1]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= S_IDLE;
         prev_q <= 1'b1;
         tcnt_q <= '0;
         idx_q  <= '0;
         vec_q  <= '1;
         fmt_q  <= FMT_8N;
         ts_q   <= 1'b0;
         po_q   <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         prev_q <= rxs;
         case (st_q)
            S_IDLE: begin
               if (en && prev_q && !rxs) begin
                  st_q   <= S_START;
                  tcnt_q <= '0;
                  fmt_q  <= fmt;
                  ts_q   <= two_stop;
                  po_q   <= par_odd;
               end
            end
            S_START: begin
               if (!en) st_q <= S_IDLE;
               else if (tick) begin
                  if (tcnt_q == HALF_TICK) begin
                     tcnt_q <= '0;
                     idx_q  <= '0;
                     st_q   <= rxs ? S_IDLE : S_BITS;
                  end else begin
                     tcnt_q <= tcnt_q + 1'b1;
                  end
               end
            end
            S_BITS: begin
               if (!en) st_q <= S_IDLE;
               else if (tick) begin
                  if (tcnt_q == FULL_TICK) begin
                     tcnt_q       <= '0;
                     vec_q[idx_q] <= rxs;
                     if (idx_q == last_idx) begin
                        st_q   <= S_IDLE;
                        done_q <= 1'b1;
                     end else begin
                        idx_q <= idx_q + 1'b1;
                     end
                  end else begin
                     tcnt_q <= tcnt_q + 1'b1;
                  end
               end
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end

   assign done = done_q;

   AST_RX_DONE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> $past(en)); // R5
   AST_RX_START_CONFIRMED: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_BITS && $past(st_q) == S_START) |-> $past(!rxs)); // R6
   AST_RX_WAIT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != S_IDLE && !tick) |=> $stable(tcnt_q)); // R12
endmodule

// File: rtl/sfe_stat.sv
module sfe_stat #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          done,
   input  logic [DW-1:0] rbyte,
   input  logic          par_bad,
   input  logic          stop_bad,
   input  logic          chk_par,
   input  logic          chk_frame,
   input  logic          chk_ovr,
   input  logic          cmd_wr,
   input  logic          cmd_rx_on,
   input  logic          cmd_rx_off,
   input  logic          cmd_clr_frame,
   input  logic          cmd_clr_par,
   input  logic          cmd_clr_ovr,
   input  logic          rd,
   output logic          rx_en,
   output logic [DW-1:0] rx_data,
   output logic          rx_avail,
   output logic          fe,
   output logic          pe,
   output logic          oe
);
   logic          en_q, avail_q, fe_q, pe_q, oe_q;
   logic [DW-1:0] data_q;
   logic          room, accept, lost;

   assign room   = !avail_q || rd;
   assign accept = done && room;
   assign lost   = done && !room;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         avail_q <= 1'b0;
         data_q  <= '0;
         fe_q    <= 1'b0;
         pe_q    <= 1'b0;
         oe_q    <= 1'b0;
      end else begin
         if (cmd_wr && cmd_rx_on)       en_q <= 1'b1;
         else if (cmd_wr && cmd_rx_off) en_q <= 1'b0;

         if (accept) begin
            avail_q <= 1'b1;
            data_q  <= rbyte;
         end else if (rd) begin
            avail_q <= 1'b0;
         end

         if (accept && stop_bad && chk_frame) fe_q <= 1'b1;
         else if (cmd_wr && cmd_clr_frame)    fe_q <= 1'b0;

         if (accept && par_bad && chk_par)    pe_q <= 1'b1;
         else if (cmd_wr && cmd_clr_par)      pe_q <= 1'b0;

         if (lost && chk_ovr)                 oe_q <= 1'b1;
         else if (cmd_wr && cmd_clr_ovr)      oe_q <= 1'b0;
      end
   end

   assign rx_en    = en_q;
   assign rx_avail = avail_q;
   assign rx_data  = data_q;
   assign fe       = fe_q;
   assign pe       = pe_q;
   assign oe       = oe_q;

   AST_FE_CLEAR_BY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fe_q) |-> $past(cmd_wr && cmd_clr_frame)); // R11
   AST_PE_CLEAR_BY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pe_q) |-> $past(cmd_wr && cmd_clr_par)); // R11
   AST_OE_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oe_q) |-> $past(done && avail_q && !rd)); // R10
   AST_HELD_BYTE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (avail_q && !rd) |=> $stable(data_q)); // R10
endmodule

// File: rtl/serial_frame_engine.sv
module serial_frame_engine
   import sfe_pkg::*;
#(
   parameter int OSR         = 16,
   parameter int DW          = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          os_tick,
   input  logic [1:0]    cfg_fmt,
   input  logic          cfg_two_stop,
   input  logic          cfg_par_odd,
   input  logic          cfg_par_chk,
   input  logic          cfg_frame_chk,
   input  logic          cfg_ovr_chk,
   input  logic          cmd_wr,
   input  logic          cmd_rx_on,
   input  logic          cmd_rx_off,
   input  logic          cmd_clr_frame,
   input  logic          cmd_clr_par,
   input  logic          cmd_clr_ovr,
   input  logic          tx_wr,
   input  logic [DW-1:0] tx_data,
   output logic          tx_empty,
   output logic          txd,
   input  logic          rxd,
   input  logic          rx_rd,
   output logic [DW-1:0] rx_data,
   output logic          rx_avail,
   output logic          rx_enabled,
   output logic          err_frame,
   output logic          err_parity,
   output logic          err_overrun
);
   generate
      if (OSR < 4 || (OSR % 2) != 0) begin : g_bad_osr
         $error("OSR must be even and at least 4");
      end
      if (DW < 5 || DW > 8) begin : g_bad_dw
         $error("DW must lie between 5 and 8");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie between 0 and 4");
      end
   endgenerate

   fmt_e          fmt;
   logic          done, par_bad, stop_bad;
   logic [DW-1:0] rbyte;

   assign fmt = fmt_e'(cfg_fmt);

   sfe_tx #(.OSR(OSR), .DW(DW)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (os_tick),
      .fmt      (fmt),
      .two_stop (cfg_two_stop),
      .par_odd  (cfg_par_odd),
      .wr       (tx_wr),
      .wdata    (tx_data),
      .empty    (tx_empty),
      .txd      (txd)
   );

   sfe_rx #(.OSR(OSR), .DW(DW), .SYNC_STAGES(SYNC_STAGES)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (os_tick),
      .en       (rx_enabled),
      .fmt      (fmt),
      .two_stop (cfg_two_stop),
      .par_odd  (cfg_par_odd),
      .rxd      (rxd),
      .done     (done),
      .rbyte    (rbyte),
      .par_bad  (par_bad),
      .stop_bad (stop_bad)
   );

   sfe_stat #(.DW(DW)) u_stat (
      .clk           (clk),
      .rst_n         (rst_n),
      .done          (done),
      .rbyte         (rbyte),
      .par_bad       (par_bad),
      .stop_bad      (stop_bad),
      .chk_par       (cfg_par_chk),
      .chk_frame     (cfg_frame_chk),
      .chk_ovr       (cfg_ovr_chk),
      .cmd_wr        (cmd_wr),
      .cmd_rx_on     (cmd_rx_on),
      .cmd_rx_off    (cmd_rx_off),
      .cmd_clr_frame (cmd_clr_frame),
      .cmd_clr_par   (cmd_clr_par),
      .cmd_clr_ovr   (cmd_clr_ovr),
      .rd            (rx_rd),
      .rx_en         (rx_enabled),
      .rx_data       (rx_data),
      .rx_avail      (rx_avail),
      .fe            (err_frame),
      .pe            (err_parity),
      .oe            (err_overrun)
   );
endmodule

// File: tb/tb_serial_frame_engine.sv
module tb_serial_frame_engine;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       os_tick;
   logic [1:0] cfg_fmt = 2'b00;
   logic       cfg_two_stop = 1'b0, cfg_par_odd = 1'b0, cfg_par_chk = 1'b0;
   logic       cfg_frame_chk = 1'b0, cfg_ovr_chk = 1'b0;
   logic       cmd_wr = 1'b0, cmd_rx_on = 1'b0, cmd_rx_off = 1'b0;
   logic       cmd_clr_frame = 1'b0, cmd_clr_par = 1'b0, cmd_clr_ovr = 1'b0;
   logic       tx_wr = 1'b0;
   logic [7:0] tx_data = '0;
   logic       tx_empty, txd;
   logic       rxd = 1'b1;
   logic       rx_rd = 1'b0;
   logic [7:0] rx_data;
   logic       rx_avail, rx_enabled, err_frame, err_parity, err_overrun;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   localparam int BIT_CLKS = 32;

   always #2 clk = ~clk;

   always_ff @(posedge clk) begin
      if (!rst_n) os_tick <= 1'b0;
      else        os_tick <= ~os_tick;
   end

   serial_frame_engine dut (
      .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .cfg_fmt(cfg_fmt),
      .cfg_two_stop(cfg_two_stop), .cfg_par_odd(cfg_par_odd),
      .cfg_par_chk(cfg_par_chk), .cfg_frame_chk(cfg_frame_chk),
      .cfg_ovr_chk(cfg_ovr_chk), .cmd_wr(cmd_wr), .cmd_rx_on(cmd_rx_on),
      .cmd_rx_off(cmd_rx_off), .cmd_clr_frame(cmd_clr_frame),
      .cmd_clr_par(cmd_clr_par), .cmd_clr_ovr(cmd_clr_ovr),
      .tx_wr(tx_wr), .tx_data(tx_data), .tx_empty(tx_empty), .txd(txd),
      .rxd(rxd), .rx_rd(rx_rd), .rx_data(rx_data), .rx_avail(rx_avail),
      .rx_enabled(rx_enabled), .err_frame(err_frame),
      .err_parity(err_parity), .err_overrun(err_overrun)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic build(input logic [1:0] f, input logic [7:0] d, input logic two,
                        input logic odd, output logic [11:0] v, output int n);
      int  nd;
      logic hp, ones;
      nd = (f == 2'b10) ? 7 : 8;
      hp = (f == 2'b01) || (f == 2'b10);
      v = '1;
      v[0] = 1'b0;
      ones = 1'b0;
      for (int i = 0; i < nd; i++) begin
         v[1+i] = d[i];
         ones ^= d[i];
      end
      if (hp) v[1+nd] = ones ^ odd;
      n = 1 + nd + (hp ? 1 : 0) + (two ? 2 : 1);
   endtask

   task automatic txw(input logic [7:0] d);
      @(negedge clk); tx_wr = 1'b1; tx_data = d;
      @(negedge clk); tx_wr = 1'b0;
   endtask

   task automatic cap_tx(input int n, output logic [11:0] v);
      v = '1;
      while (txd !== 1'b0) @(negedge clk);
      repeat (BIT_CLKS/2) @(negedge clk);
      for (int i = 0; i < n; i++) begin
         v[i] = txd;
         if (i < n-1) repeat (BIT_CLKS) @(negedge clk);
      end
   endtask

   task automatic cmd(input logic on, input logic off, input logic cf,
                      input logic cp, input logic co);
      @(negedge clk);
      cmd_wr = 1'b1; cmd_rx_on = on; cmd_rx_off = off;
      cmd_clr_frame = cf; cmd_clr_par = cp; cmd_clr_ovr = co;
      @(negedge clk);
      cmd_wr = 1'b0; cmd_rx_on = 1'b0; cmd_rx_off = 1'b0;
      cmd_clr_frame = 1'b0; cmd_clr_par = 1'b0; cmd_clr_ovr = 1'b0;
   endtask

   task automatic rd_pulse();
      @(negedge clk); rx_rd = 1'b1;
      @(negedge clk); rx_rd = 1'b0;
   endtask

   task automatic rx_send(input logic [7:0] d, input logic [11:0] flip);
      logic [11:0] v;
      int n;
      build(cfg_fmt, d, cfg_two_stop, cfg_par_odd, v, n);
      v ^= flip;
      for (int i = 0; i < n; i++) begin
         @(negedge clk); rxd = v[i];
         repeat (BIT_CLKS-1) @(negedge clk);
      end
      @(negedge clk); rxd = 1'b1;
      repeat (2*BIT_CLKS) @(negedge clk);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R4 txd idle", txd, 1);
      chk("R4 tx_empty", tx_empty, 1);
      chk("R7 rx_avail", rx_avail, 0);
      chk("R5 rx_enabled", rx_enabled, 0);
      chk("R11 flags", {err_frame, err_parity, err_overrun}, 0);
   endtask

   task automatic t_tx_frame(input logic [1:0] f, input logic two, input logic odd,
                             input logic [7:0] d, input string tag);
      logic [11:0] got, exp;
      int n;
      cfg_fmt = f; cfg_two_stop = two; cfg_par_odd = odd;
      build(f, d, two, odd, exp, n);
      txw(d);
      @(negedge clk);
      chk("R4 empty after load", tx_empty, 1);
      cap_tx(n, got);
      chk(tag, got, exp);
      repeat (3*BIT_CLKS) @(negedge clk);
   endtask

   task automatic t_tx_buffer();
      logic [11:0] got, exp;
      int n, lows;
      cfg_fmt = 2'b00; cfg_two_stop = 1'b0;
      txw(8'h11);
      txw(8'h22);
      chk("R4 buffer full", tx_empty, 0);
      txw(8'h33);
      build(2'b00, 8'h11, 1'b0, 1'b0, exp, n);
      cap_tx(n, got);
      chk("R4 first frame", got, exp);
      build(2'b00, 8'h22, 1'b0, 1'b0, exp, n);
      cap_tx(n, got);
      chk("R4 second frame", got, exp);
      lows = 0;
      for (int i = 0; i < 20*BIT_CLKS; i++) begin
         @(negedge clk);
         if (txd == 1'b0) lows++;
      end
      chk("R4 write while full ignored", lows, 0);
      chk("R4 empty at end", tx_empty, 1);
   endtask

   task automatic t_rx_disabled();
      cfg_fmt = 2'b00; cfg_two_stop = 1'b0;
      rx_send(8'h5A, 12'h0);
      chk("R5 no rx while disabled", rx_avail, 0);
      cmd(1, 0, 0, 0, 0);
      chk("R5 enable set", rx_enabled, 1);
   endtask

   task automatic t_rx_basic();
      cfg_fmt = 2'b00; cfg_frame_chk = 1'b1; cfg_par_chk = 1'b1; cfg_ovr_chk = 1'b1;
      rx_send(8'h3C, 12'h0);
      chk("R7 avail", rx_avail, 1);
      chk("R7 data", rx_data, 8'h3C);
      chk("R11 no flags", {err_frame, err_parity, err_overrun}, 0);
      rd_pulse();
      chk("R7 read clears", rx_avail, 0);
   endtask

   task automatic t_rx_glitch();
      @(negedge clk); rxd = 1'b0;
      repeat (6) @(negedge clk);
      rxd = 1'b1;
      repeat (20*BIT_CLKS) @(negedge clk);
      chk("R6 glitch rejected", rx_avail, 0);
      rx_send(8'h81, 12'h0);
      chk("R6 frame after glitch", rx_data, 8'h81);
      rd_pulse();
   endtask

   task automatic t_rx_7bit();
      cfg_fmt = 2'b10; cfg_par_odd = 1'b0; cfg_two_stop = 1'b0;
      rx_send(8'hD5, 12'h0);
      chk("R7 7-bit data", {rx_avail, rx_data}, {1'b1, 8'h55});
      chk("R3 7-bit parity ok", err_parity, 0);
      rd_pulse();
   endtask

   task automatic t_rx_parity();
      cfg_fmt = 2'b01; cfg_par_odd = 1'b1; cfg_par_chk = 1'b1;
      rx_send(8'h0F, 12'h200);
      chk("R8 parity error", err_parity, 1);
      chk("R8 byte delivered", rx_data, 8'h0F);
      rd_pulse();
      cmd(0, 0, 1, 0, 1);
      chk("R11 other clears leave parity", err_parity, 1);
      cmd(0, 0, 0, 1, 0);
      chk("R11 parity cleared", err_parity, 0);
      cfg_par_chk = 1'b0;
      rx_send(8'h0F, 12'h200);
      chk("R8 check disabled", err_parity, 0);
      rd_pulse();
      cfg_par_chk = 1'b1;
      rx_send(8'h0F, 12'h0);
      chk("R3 odd parity accepted", err_parity, 0);
      rd_pulse();
   endtask

   task automatic t_rx_frame();
      cfg_fmt = 2'b00; cfg_two_stop = 1'b0; cfg_frame_chk = 1'b1;
      rx_send(8'hA7, 12'h200);
      chk("R9 framing error", err_frame, 1);
      chk("R11 parity untouched", err_parity, 0);
      rd_pulse();
      cmd(0, 0, 1, 0, 0);
      chk("R11 frame cleared", err_frame, 0);
      cfg_frame_chk = 1'b0;
      rx_send(8'hA7, 12'h200);
      chk("R9 check disabled", err_frame, 0);
      rd_pulse();
      cfg_frame_chk = 1'b1; cfg_two_stop = 1'b1;
      rx_send(8'h66, 12'h400);
      chk("R2 second stop low", err_frame, 1);
      chk("R2 data two stops", rx_data, 8'h66);
      rd_pulse();
      cmd(0, 0, 1, 0, 0);
      rx_send(8'h67, 12'h0);
      chk("R2 two stops clean", {err_frame, rx_data}, {1'b0, 8'h67});
      rd_pulse();
      cfg_two_stop = 1'b0;
   endtask

   task automatic t_rx_overrun();
      cfg_fmt = 2'b00; cfg_ovr_chk = 1'b1;
      rx_send(8'h12, 12'h0);
      rx_send(8'h34, 12'h0);
      chk("R10 overrun", err_overrun, 1);
      chk("R10 first kept", rx_data, 8'h12);
      rd_pulse();
      cmd(0, 0, 0, 0, 1);
      chk("R11 overrun cleared", err_overrun, 0);
      cfg_ovr_chk = 1'b0;
      rx_send(8'h56, 12'h0);
      rx_send(8'h78, 12'h0);
      chk("R10 check disabled", {err_overrun, rx_data}, {1'b0, 8'h56});
      rd_pulse();
   endtask

   task automatic t_rx_enable_cmds();
      cmd(1, 1, 0, 0, 0);
      chk("R5 set wins", rx_enabled, 1);
      cmd(0, 1, 0, 0, 0);
      chk("R5 disable", rx_enabled, 0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_tx_frame(2'b00, 1'b0, 1'b0, 8'hA5, "R1 8-bit no parity");
      t_tx_frame(2'b01, 1'b1, 1'b1, 8'h5A, "R3 8-bit odd two stop R2");
      t_tx_frame(2'b10, 1'b0, 1'b0, 8'hC3, "R1 7-bit even");
      t_tx_frame(2'b11, 1'b0, 1'b1, 8'h96, "R1 reserved as 8-bit");
      t_tx_buffer();
      t_rx_disabled();
      t_rx_basic();
      t_rx_glitch();
      t_rx_7bit();
      t_rx_parity();
      t_rx_frame();
      t_rx_overrun();
      t_rx_enable_cmds();
      if (!finished) begin
         finished = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule